// File: doc/BRIEF.md
# Bidirectional Sync Pulse Controller

This block owns a periodic synchronization pulse that shares one pin between two roles. In receive mode it synchronizes the pin, finds rising edges, measures the spacing between the first two edges in device-clock cycles and keeps a free-running phase counter locked to that spacing. After that, every edge's offset from the counter's zero point is reported, and an optional check traps any edge that lands off that zero point. In drive mode the same phase counter fires a one-cycle pulse each time it wraps, so the pin can be regenerated at the measured rate.

The intended flow is to calibrate first and then hand over. Software holds the block in receive mode until the ready flag rises, then flips the direction bit. The phase counter keeps running through the switch, so the first driven pulse lands on the grid that the received edges set up. A disable bit keeps the block from ever generating the pulse itself, for systems that must follow an external reference only. A software reset clears the capture state, the error state and the measured ratio without touching the device reset.

Top module: `sync_pulse_ctrl`

## Requirements
- R1: After the device reset, `state` reads 0 (idle), `captured`, `ready` and `align_err` are 0, `ratio` equals `DEF_RATIO` (256), `delay` is 0 and `pulse_out` is 0.
- R2: `pulse_oe` is 1 exactly when `dir_in` is 0 (drive mode), and `pulse_out` stays 0 whenever `dir_in` is 1 (receive mode).
- R3: In receive mode from idle, the first rising edge of `pulse_in` sets `captured` and moves `state` through 1 (edge seen) to 2 (calibrating), with `ready` still 0.
- R4: The next rising edge while calibrating loads `ratio` with the spacing of the two edges in clock cycles, sets `ready` and moves `state` to 3 (running); `ratio` then holds.
- R5: In state 3 with `dir_in` 0 and `gen_disable` 0, `pulse_out` is a one-cycle pulse repeating every `ratio` cycles, continuing the phase established by the received edges.
- R6: In drive mode from idle with `gen_disable` 0 and no calibration, the block enters state 3 and pulses every `DEF_RATIO` cycles.
- R7: With `gen_disable` 1, `pulse_out` stays 0 in every state, and in drive mode the block stays in state 0.
- R8: In state 3 and receive mode, each rising edge loads `delay` with the phase offset of that edge; an edge spaced a whole number of `ratio` periods from the calibration edges gives 0.
- R9: With `align_chk_en` 1 in state 3 and receive mode, an edge with non-zero offset moves `state` to 4 (error) and sets `align_err`; both hold, and `pulse_out` stays 0, until a reset.
- R10: With `align_chk_en` 0, an off-grid edge only updates `delay`; `state` stays 3 and `align_err` stays 0.
- R11: In drive mode, edges on `pulse_in` leave `state`, `delay` and `align_err` unchanged.
- R12: One cycle of `soft_rst` returns `state` to 0 and clears `captured`, `ready`, `align_err` and `delay`, with `ratio` back at `DEF_RATIO`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_in | input | 1 | 1 = receive the pulse, 0 = drive it |
| gen_disable | input | 1 | Forbids internal pulse generation |
| align_chk_en | input | 1 | Enables trapping of off-grid edges |
| soft_rst | input | 1 | Synchronous software reset of the controller |
| pulse_in | input | 1 | Pin value in receive mode (asynchronous) |
| pulse_out | output | 1 | Generated pulse |
| pulse_oe | output | 1 | Output enable for the pin driver |
| captured | output | 1 | A first edge has been captured |
| ready | output | 1 | Period measurement finished |
| align_err | output | 1 | Sticky misalignment flag |
| ratio | output | RATIO_W | Pulse period in clock cycles |
| delay | output | RATIO_W | Phase offset of the latest received edge |
| state | output | 3 | Controller state: 0 idle, 1 edge seen, 2 calibrating, 3 running, 4 error |

## Verification
A wrong phase counter shows up at the ports within one period: in drive mode the pulse spacing deviates from `ratio`, and in receive mode an on-grid edge reports a non-zero `delay` at the edge that follows the fault. A wrong measurement count appears directly on `ratio` one cycle after the second edge, and a wrong state transition is visible on `state` or on the sticky flag no later than the next received edge. The bench therefore compares spacing, offset and flags against edge times it schedules itself, and checks that the error state survives later on-grid edges and a direction change.

// File: rtl/sps_pkg.sv
// Shared type for the sync pulse controller.
// Assumes: state codes are visible on the top-level status port, so values are fixed.
package sps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_EDGE  = 3'd1,
        ST_CALIB = 3'd2,
        ST_GEN   = 3'd3,
        ST_ERR   = 3'd4
    } sps_state_e;
endpackage

// File: rtl/sps_edge_sync.sv
// Brings the asynchronous pin into the clock domain and flags rising transitions.
// Assumes: SYNC_STAGES >= 2; the flag is one cycle wide per rising transition.
module sps_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    // Shift the pin through the synchronizer and keep the previous synchronized value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            prev <= chain[SYNC_STAGES-1];
        end
    end

    // Rising transition of the synchronized pin.
    assign rise_o = chain[SYNC_STAGES-1] & ~prev;

    assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/sps_phase_ctr.sv
// Phase counter that wraps to zero every `ratio` cycles while running.
// Assumes: start has priority over run; a ratio of 0 or 1 keeps the counter at zero.
module sps_phase_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] start_val,
    input  logic         run,
    input  logic [W-1:0] ratio,
    output logic [W-1:0] ph,
    output logic         at_zero
);
    logic [W-1:0] last;

    // Highest phase value before the wrap.
    always_comb begin
        last = (ratio <= W'(1)) ? '0 : ratio - W'(1);
    end

    // Load on start, otherwise count and wrap while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (start) begin
            ph <= start_val;
        end else if (run) begin
            ph <= (ph >= last) ? '0 : ph + W'(1);
        end
    end

    assign at_zero = (ph == '0);

    assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ratio > W'(1)) |-> (ph < ratio));
endmodule

// File: rtl/sps_ctrl.sv
// Controller: idle / edge-seen / calibrating / running / error, plus the
// period measurement and the status registers.
// Assumes: edge_i is a one-cycle synchronized rising-edge flag; soft_rst acts
// like the device reset on everything this module holds.
module sps_ctrl import sps_pkg::*; #(
    parameter int W         = 16,
    parameter int DEF_RATIO = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         dir_in,
    input  logic         gen_disable,
    input  logic         align_chk_en,
    input  logic         edge_i,
    input  logic [W-1:0] ph,
    input  logic         ph_zero,
    output sps_state_e   st,
    output logic         captured,
    output logic         ready,
    output logic         align_err,
    output logic [W-1:0] ratio,
    output logic [W-1:0] delay,
    output logic         ph_start,
    output logic [W-1:0] ph_start_val,
    output logic         ph_run
);
    localparam logic [W-1:0] RATIO_RST = W'(DEF_RATIO);
    localparam logic [W-1:0] MEAS_MAX  = '1;

    sps_state_e   nx;
    logic         in_edge;
    logic [W-1:0] meas;

    assign in_edge = edge_i & dir_in;
    assign ph_run  = (st == ST_GEN);

    // Next-state choice and phase-counter load requests.
    always_comb begin
        nx           = st;
        ph_start     = 1'b0;
        ph_start_val = '0;
        case (st)
            ST_IDLE: begin
                if (in_edge) begin
                    nx = ST_EDGE;
                end else if (!dir_in && !gen_disable) begin
                    nx       = ST_GEN;
                    ph_start = 1'b1;
                end
            end
            ST_EDGE:  nx = ST_CALIB;
            ST_CALIB: begin
                if (in_edge) begin
                    nx           = ST_GEN;
                    ph_start     = 1'b1;
                    ph_start_val = W'(1);
                end
            end
            ST_GEN: begin
                if (in_edge && align_chk_en && !ph_zero) nx = ST_ERR;
            end
            ST_ERR:   nx = ST_ERR;
            default:  nx = ST_IDLE;
        endcase
        if (soft_rst) begin
            nx       = ST_IDLE;
            ph_start = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nx;
    end

    // Measurement counter and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            captured  <= 1'b0;
            ready     <= 1'b0;
            align_err <= 1'b0;
            ratio     <= RATIO_RST;
            delay     <= '0;
            meas      <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (in_edge) begin
                        captured <= 1'b1;
                        meas     <= W'(1);
                    end
                end
                ST_EDGE, ST_CALIB: begin
                    if (meas != MEAS_MAX) meas <= meas + W'(1);
                    if (st == ST_CALIB && in_edge) begin
                        ratio <= meas;
                        ready <= 1'b1;
                    end
                end
                ST_GEN: begin
                    if (in_edge) begin
                        delay <= ph;
                        if (align_chk_en && !ph_zero) align_err <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (align_err && !soft_rst) |=> align_err);
    assert_err_state_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERR) |-> align_err);
    assert_ready_after_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> captured);
    assert_ratio_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GEN && !soft_rst) |=> $stable(ratio));
    assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st == ST_IDLE && !captured && !ready && !align_err));
endmodule

// File: rtl/sync_pulse_ctrl.sv
// Top level: shares one pulse pin between receive (measure and check) and
// drive (regenerate at the measured ratio) roles.
// Assumes: pulse_in is asynchronous; the pin driver uses pulse_oe to choose direction.
module sync_pulse_ctrl import sps_pkg::*; #(
    parameter int RATIO_W     = 16,
    parameter int DEF_RATIO   = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dir_in,
    input  logic               gen_disable,
    input  logic               align_chk_en,
    input  logic               soft_rst,
    input  logic               pulse_in,
    output logic               pulse_out,
    output logic               pulse_oe,
    output logic               captured,
    output logic               ready,
    output logic               align_err,
    output logic [RATIO_W-1:0] ratio,
    output logic [RATIO_W-1:0] delay,
    output logic [2:0]         state
);
    sps_state_e         st;
    logic               rise;
    logic [RATIO_W-1:0] ph;
    logic               ph_zero;
    logic               ph_start;
    logic [RATIO_W-1:0] ph_start_val;
    logic               ph_run;

    sps_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (pulse_in),
        .rise_o (rise)
    );

    sps_ctrl #(.W(RATIO_W), .DEF_RATIO(DEF_RATIO)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .dir_in       (dir_in),
        .gen_disable  (gen_disable),
        .align_chk_en (align_chk_en),
        .edge_i       (rise),
        .ph           (ph),
        .ph_zero      (ph_zero),
        .st           (st),
        .captured     (captured),
        .ready        (ready),
        .align_err    (align_err),
        .ratio        (ratio),
        .delay        (delay),
        .ph_start     (ph_start),
        .ph_start_val (ph_start_val),
        .ph_run       (ph_run)
    );

    sps_phase_ctr #(.W(RATIO_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ph_start),
        .start_val (ph_start_val),
        .run       (ph_run),
        .ratio     (ratio),
        .ph        (ph),
        .at_zero   (ph_zero)
    );

    // Pin direction and pulse gating.
    always_comb begin
        pulse_oe  = ~dir_in;
        pulse_out = ~dir_in & ~gen_disable & (st == ST_GEN) & ph_zero;
        state     = st;
    end

    assert_pulse_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && ratio > RATIO_W'(1)) |=> !pulse_out);
endmodule

// File: tb/sync_pulse_ctrl_bench.sv
`timescale 1ns/1ps
module sync_pulse_ctrl_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         dir_in, gen_disable, align_chk_en, soft_rst, pulse_in;
    logic         pulse_out, pulse_oe, captured, ready, align_err;
    logic [W-1:0] ratio, delay;
    logic [2:0]   state;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sync_pulse_ctrl u_sync_pulse_ctrl (
        .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .gen_disable(gen_disable),
        .align_chk_en(align_chk_en), .soft_rst(soft_rst), .pulse_in(pulse_in),
        .pulse_out(pulse_out), .pulse_oe(pulse_oe), .captured(captured),
        .ready(ready), .align_err(align_err), .ratio(ratio), .delay(delay),
        .state(state)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One pulse per call iteration; consecutive pulse starts are `gap` cycles apart.
    task automatic send_pulses(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) pulse_in = 1'b1;
            @(negedge clk) pulse_in = 1'b0;
            repeat (gap - 2) @(negedge clk);
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watch pulse_out for n cycles: count highs and spacings that differ from exp_gap.
    task automatic watch_out(input int n, input int exp_gap, output int nhigh, output int nbad);
        int last;
        last  = -1;
        nhigh = 0;
        nbad  = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pulse_out) begin
                if (last >= 0 && (cyc - last) != exp_gap) nbad++;
                last = cyc;
                nhigh++;
            end
        end
    endtask

    task automatic do_soft_reset();
        @(negedge clk) soft_rst = 1'b1;
        @(negedge clk) soft_rst = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 state", state, 0);
        chk("R1 captured", captured, 0);
        chk("R1 ready", ready, 0);
        chk("R1 align_err", align_err, 0);
        chk("R1 ratio", ratio, 256);
        chk("R1 delay", delay, 0);
        chk("R1 pulse_out", pulse_out, 0);
        chk("R2 oe in receive mode", pulse_oe, 0);
    endtask

    // Calibrate at period p, then on-grid, off-grid and drive-mode behaviour.
    task automatic t_calibrate_and_track(input int p);
        int nh, nb;
        send_pulses(1, p);
        chk("R3 captured", captured, 1);
        chk("R3 state calibrating", state, 2);
        chk("R3 ready low", ready, 0);
        send_pulses(1, p);
        chk("R4 ratio", ratio, p);
        chk("R4 ready", ready, 1);
        chk("R4 state running", state, 3);
        send_pulses(3, p);
        chk("R8 on-grid delay", delay, 0);
        chk("R8 no error", align_err, 0);
        align_chk_en = 1'b0;
        idle_cycles(5);
        send_pulses(1, p);
        chk("R10 delay off-grid", delay, 5);
        chk("R10 state", state, 3);
        chk("R10 align_err", align_err, 0);
        watch_out(p - 5, p, nh, nb);
        chk("R2 no pulse in receive mode", nh, 0);
        align_chk_en = 1'b1;
        send_pulses(1, p);
        chk("R8 back on grid", delay, 0);
        chk("R8 state", state, 3);
        dir_in = 1'b0;
        watch_out(3 * p, p, nh, nb);
        chk("R2 oe in drive mode", pulse_oe, 1);
        chk("R5 pulses seen", (nh >= 2) ? 1 : 0, 1);
        chk("R5 spacing equals ratio", nb, 0);
        idle_cycles(7);
        send_pulses(1, p);
        chk("R11 state", state, 3);
        chk("R11 align_err", align_err, 0);
        chk("R11 delay", delay, 0);
        gen_disable = 1'b1;
        watch_out(2 * p, p, nh, nb);
        chk("R7 no pulse when disabled", nh, 0);
        gen_disable = 1'b0;
    endtask

    task automatic t_misalign(input int p);
        int nh, nb;
        dir_in = 1'b1;
        align_chk_en = 1'b1;
        do_soft_reset();
        send_pulses(2, p);
        chk("R4 ratio second run", ratio, p);
        idle_cycles(3);
        send_pulses(1, p);
        chk("R9 error state", state, 4);
        chk("R9 align_err", align_err, 1);
        chk("R9 delay", delay, 3);
        dir_in = 1'b0;
        watch_out(2 * p, p, nh, nb);
        chk("R9 no pulse in error", nh, 0);
        dir_in = 1'b1;
        send_pulses(1, p);
        chk("R9 sticky", align_err, 1);
        chk("R9 state holds", state, 4);
        do_soft_reset();
        chk("R12 state", state, 0);
        chk("R12 captured", captured, 0);
        chk("R12 ready", ready, 0);
        chk("R12 align_err", align_err, 0);
        chk("R12 ratio", ratio, 256);
        chk("R12 delay", delay, 0);
    endtask

    task automatic t_uncalibrated_drive();
        int nh, nb;
        dir_in = 1'b0;
        watch_out(600, 256, nh, nb);
        chk("R6 state running", state, 3);
        chk("R6 pulses seen", (nh >= 2) ? 1 : 0, 1);
        chk("R6 spacing default", nb, 0);
    endtask

    task automatic t_disabled_idle();
        int nh, nb;
        gen_disable = 1'b1;
        do_soft_reset();
        idle_cycles(10);
        chk("R7 stays idle", state, 0);
        watch_out(300, 256, nh, nb);
        chk("R7 no pulse from idle", nh, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        dir_in = 1'b1;
        gen_disable = 1'b0;
        align_chk_en = 1'b1;
        soft_rst = 1'b0;
        pulse_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_calibrate_and_track(40);
        t_misalign(30);
        t_uncalibrated_drive();
        t_disabled_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule